// File: doc/BRIEF.md
# Channel interrupt status latch

This block holds one interrupt-pending flag for each of the two channels of an IDE storage controller. Each channel's drive logic reports an interrupt event as a valid strobe with an eight-bit status byte. Bit 2 of that byte marks a real interrupt; when it is present the channel's flag is set on the next clock edge. Software sees the flags in two places. The first is the configuration space, where a read of the channel's own register also clears that flag. The second is a vendor byte in the bus-master register window, where writing a one to a flag's bit clears it.

The same vendor byte holds four upper control bits. In the extended variant two of these bits stop a channel's events from reaching the bus-master DMA engine's interrupt input. The block passes every bus-master write on to the DMA engine. At the vendor offset it passes on only the two low data bits. It also drives a host interrupt line: the OR of the unmasked flags, registered for one cycle. While reset is held, both forward channels carry a zero status event, and after reset every flag and control bit is clear.

Top module: `chirq_latch`

## Requirements
- R1: A valid event whose status has bit 2 set sets that channel's flag at the next clock edge. The channel 0 flag reads at bit 2 of configuration address 0x50 and at bit 2 of bus-master offset 1. The channel 1 flag reads at bit 4 of configuration address 0x57 and at bit 3 of bus-master offset 1.
- R2: A valid event whose status has bit 2 clear leaves the flag unchanged, whether the flag is set or clear.
- R3: `cfg_rdata` shows the current flag in its bit position for address 0x50 or 0x57, with all other bits zero, and shows zero for any other address. A read strobe at 0x50 clears the channel 0 flag at the next edge, and a strobe at 0x57 clears the channel 1 flag. A strobe at any other address clears nothing.
- R4: A bus-master write at offset 1 clears the channel 0 flag if data bit 2 is one and clears the channel 1 flag if data bit 3 is one. The same write stores data bits 7:4 as the vendor control bits. A write at any other offset changes neither the flags nor the vendor bits.
- R5: Every bus-master write raises `dma_wr` in the same cycle. At offset 1, `dma_wdata` carries data bits 1:0 and has bits 7:2 zero. At any other offset it carries the full data byte.
- R6: `bm_rdata` at offset 1 is {vendor bits 7:4, channel 1 flag, channel 0 flag, 2'b00}. At every other offset it reads zero.
- R7: When an event sets a flag in the same cycle as a clear by read or by write, the flag ends up set.
- R8: In the extended variant, vendor bit 4 blocks channel 0 events from `fwd_valid[0]` and vendor bit 5 blocks channel 1 events from `fwd_valid[1]`. In the base variant no event is blocked. `fwd_status` carries the event status bytes unchanged, with channel 0 in bits 7:0.
- R9: `irq_out` equals the OR of the flags that are not masked, as they stood one clock earlier.
- R10: While `rst_n` is low, `fwd_valid` is 2'b11 and `fwd_status` is zero. Reset clears both flags, the vendor bits and `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 2 | Per-channel event strobe |
| evt_status | input | 16 | Event status bytes, channel 0 in bits 7:0 |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration read address |
| cfg_rdata | output | 8 | Configuration read data |
| bm_wr | input | 1 | Bus-master register write strobe |
| bm_addr | input | 4 | Bus-master register offset |
| bm_wdata | input | 8 | Bus-master write data |
| bm_rdata | output | 8 | Bus-master vendor read data |
| dma_wr | output | 1 | Write strobe passed to the DMA engine |
| dma_wdata | output | 8 | Write data passed to the DMA engine |
| fwd_valid | output | 2 | Events forwarded to the DMA interrupt input |
| fwd_status | output | 16 | Status bytes forwarded with the events |
| irq_out | output | 1 | Registered host interrupt |

## Verification
A flag left stuck or cleared by mistake shows up on the first read of either register window. Because the two windows show the same flag, they disagree if only one path is broken. The same fault reaches `irq_out` one cycle after the flag change, so a wrong flag or mask bit surfaces within two cycles at most. Faults in forwarding, masking and data trimming appear in the same cycle at `fwd_valid` and `dma_wdata`. Same-cycle set and clear collisions are aimed at directly, because a wrong priority there loses an interrupt silently.

// File: rtl/chirq_pkg.sv
`timescale 1ns/1ps
package chirq_pkg;
    localparam int NCH     = 2;
    localparam int SW      = 8;
    localparam int SET_BIT = 2;
    localparam int VENDW   = 4;

    typedef struct packed {
        logic [VENDW-1:0] vend;
        logic             irq;
    } top_state_t;
endpackage

// File: rtl/chirq_flag.sv
`timescale 1ns/1ps
module chirq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_in,
    input  logic clr_in,
    output logic flag_q
);
    logic flag_d;

    always_comb begin
        flag_d = flag_q;
        if (clr_in) flag_d = 1'b0;
        if (set_in) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end
endmodule

// File: rtl/chirq_fwd.sv
`timescale 1ns/1ps
module chirq_fwd #(
    parameter int NCH = 2,
    parameter int SW  = 8
) (
    input  logic              rst_n,
    input  logic [NCH-1:0]    evt_valid,
    input  logic [NCH*SW-1:0] evt_status,
    input  logic [NCH-1:0]    mask,
    output logic [NCH-1:0]    fwd_valid,
    output logic [NCH*SW-1:0] fwd_status
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_comb begin
            if (!rst_n) begin
                fwd_valid[c]            = 1'b1;
                fwd_status[c*SW +: SW]  = '0;
            end else begin
                fwd_valid[c]            = evt_valid[c] & ~mask[c];
                fwd_status[c*SW +: SW]  = evt_status[c*SW +: SW];
            end
        end
    end
endmodule

// File: rtl/chirq_latch.sv
`timescale 1ns/1ps
module chirq_latch
    import chirq_pkg::*;
#(
    parameter bit              EXTENDED = 1'b1,
    parameter logic [7:0]      CFG_CH0  = 8'h50,
    parameter logic [7:0]      CFG_CH1  = 8'h57,
    parameter int              BMW      = 4,
    parameter logic [BMW-1:0]  BM_VEND  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    evt_valid,
    input  logic [NCH*SW-1:0] evt_status,
    input  logic              cfg_rd,
    input  logic [7:0]        cfg_addr,
    output logic [7:0]        cfg_rdata,
    input  logic              bm_wr,
    input  logic [BMW-1:0]    bm_addr,
    input  logic [7:0]        bm_wdata,
    output logic [7:0]        bm_rdata,
    output logic              dma_wr,
    output logic [7:0]        dma_wdata,
    output logic [NCH-1:0]    fwd_valid,
    output logic [NCH*SW-1:0] fwd_status,
    output logic              irq_out
);
    localparam int CFG_POS0 = 2;
    localparam int CFG_POS1 = 4;
    localparam int BM_FLAG0 = 2;

    top_state_t st_d, st_q;
    logic [NCH-1:0] flag_q;
    logic [NCH-1:0] set_ev, clr_ev, mask;
    logic           bm_hit;

    assign bm_hit = bm_wr && (bm_addr == BM_VEND);
    assign mask   = EXTENDED ? st_q.vend[NCH-1:0] : '0;

    for (genvar c = 0; c < NCH; c++) begin : g_flag
        localparam logic [7:0] CADDR = (c == 0) ? CFG_CH0 : CFG_CH1;
        assign set_ev[c] = evt_valid[c] && evt_status[c*SW + SET_BIT];
        assign clr_ev[c] = (cfg_rd && (cfg_addr == CADDR)) ||
                           (bm_hit && bm_wdata[BM_FLAG0 + c]);
        chirq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_in (set_ev[c]),
            .clr_in (clr_ev[c]),
            .flag_q (flag_q[c])
        );
    end

    chirq_fwd #(.NCH(NCH), .SW(SW)) u_fwd (
        .rst_n      (rst_n),
        .evt_valid  (evt_valid),
        .evt_status (evt_status),
        .mask       (mask),
        .fwd_valid  (fwd_valid),
        .fwd_status (fwd_status)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(flag_q & ~mask);
        if (bm_hit) st_d.vend = bm_wdata[7:8-VENDW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == CFG_CH0)      cfg_rdata[CFG_POS0] = flag_q[0];
        else if (cfg_addr == CFG_CH1) cfg_rdata[CFG_POS1] = flag_q[1];
    end

    always_comb begin
        bm_rdata = '0;
        if (bm_addr == BM_VEND)
            bm_rdata = {st_q.vend, flag_q[1], flag_q[0], 2'b00};
    end

    assign dma_wr    = bm_wr;
    assign dma_wdata = (bm_addr == BM_VEND) ? {6'b0, bm_wdata[1:0]} : bm_wdata;
    assign irq_out   = st_q.irq;
endmodule

// File: rtl/chirq_latch_chk.sv
`timescale 1ns/1ps
module chirq_latch_chk #(
    parameter logic [7:0] CFG_CH0 = 8'h50,
    parameter logic [7:0] CFG_CH1 = 8'h57,
    parameter int         BMW     = 4,
    parameter logic [BMW-1:0] BM_VEND = 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     evt_valid,
    input logic [15:0]    evt_status,
    input logic           cfg_rd,
    input logic [7:0]     cfg_addr,
    input logic           bm_wr,
    input logic [BMW-1:0] bm_addr,
    input logic [7:0]     bm_wdata,
    input logic [7:0]     dma_wdata,
    input logic [1:0]     fwd_valid,
    input logic [15:0]    fwd_status,
    input logic           irq_out,
    input logic [1:0]     flag_q,
    input logic [1:0]     mask
);
    // R1
    set_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid[0] && evt_status[2]) |=> flag_q[0]);
    // R1
    set_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid[1] && evt_status[10]) |=> flag_q[1]);
    // R2
    hold_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(evt_valid[0] && evt_status[2]) && !(cfg_rd && cfg_addr == CFG_CH0) &&
         !(bm_wr && bm_addr == BM_VEND && bm_wdata[2])) |=> $stable(flag_q[0]));
    // R3
    cfg_clr_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == CFG_CH1 && !(evt_valid[1] && evt_status[10])) |=> !flag_q[1]);
    // R4
    bm_clr_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_wr && bm_addr == BM_VEND && bm_wdata[2] && !(evt_valid[0] && evt_status[2])) |=> !flag_q[0]);
    // R4
    bm_clr_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_wr && bm_addr == BM_VEND && bm_wdata[3] && !(evt_valid[1] && evt_status[10])) |=> !flag_q[1]);
    // R5
    dma_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_wr && bm_addr == BM_VEND) |-> (dma_wdata[7:2] == 6'b0));
    // R5
    dma_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_wr && bm_addr != BM_VEND) |-> (dma_wdata == bm_wdata));
    // R8
    fwd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid[0] && mask[0]) |-> !fwd_valid[0]);
    // R8
    fwd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (fwd_status == evt_status));
    // R9
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(flag_q & ~mask))));
endmodule

bind chirq_latch chirq_latch_chk #(
    .CFG_CH0 (CFG_CH0),
    .CFG_CH1 (CFG_CH1),
    .BMW     (BMW),
    .BM_VEND (BM_VEND)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_status (evt_status),
    .cfg_rd     (cfg_rd),
    .cfg_addr   (cfg_addr),
    .bm_wr      (bm_wr),
    .bm_addr    (bm_addr),
    .bm_wdata   (bm_wdata),
    .dma_wdata  (dma_wdata),
    .fwd_valid  (fwd_valid),
    .fwd_status (fwd_status),
    .irq_out    (irq_out),
    .flag_q     (flag_q),
    .mask       (mask)
);

// File: tb/chirq_latch_test.sv
`timescale 1ns/1ps
module chirq_latch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  evt_valid = '0;
    logic [15:0] evt_status = '0;
    logic        cfg_rd = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_rdata;
    logic        bm_wr = 1'b0;
    logic [3:0]  bm_addr = '0;
    logic [7:0]  bm_wdata = '0;
    logic [7:0]  bm_rdata;
    logic        dma_wr;
    logic [7:0]  dma_wdata;
    logic [1:0]  fwd_valid;
    logic [15:0] fwd_status;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    logic [1:0] m_flag = '0;
    logic [3:0] m_vend = '0;
    logic       m_irq  = 1'b0;

    always #2.5 clk = ~clk;

    chirq_latch uut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_status(evt_status),
        .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
        .bm_wr(bm_wr), .bm_addr(bm_addr), .bm_wdata(bm_wdata), .bm_rdata(bm_rdata),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata), .fwd_valid(fwd_valid),
        .fwd_status(fwd_status), .irq_out(irq_out)
    );

    task automatic check(input [15:0] act, input [15:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic [7:0] exp_cfg(input [7:0] a);
        exp_cfg = 8'h00;
        if (a == 8'h50) exp_cfg[2] = m_flag[0];
        else if (a == 8'h57) exp_cfg[4] = m_flag[1];
    endfunction

    function automatic [7:0] exp_bm(input [3:0] a);
        exp_bm = (a == 4'd1) ? {m_vend, m_flag[1], m_flag[0], 2'b00} : 8'h00;
    endfunction

    function automatic [7:0] exp_dma(input [3:0] a, input [7:0] d);
        exp_dma = (a == 4'd1) ? {6'b0, d[1:0]} : d;
    endfunction

    task automatic cyc(input [1:0] ev, input [15:0] st, input cr, input [7:0] ca,
                       input bw, input [3:0] ba, input [7:0] bd);
        logic [1:0] mk;
        logic       irq_n;
        logic       hit;
        @(negedge clk);
        evt_valid = ev; evt_status = st; cfg_rd = cr; cfg_addr = ca;
        bm_wr = bw; bm_addr = ba; bm_wdata = bd;
        #1;
        check({8'h0, cfg_rdata}, {8'h0, exp_cfg(ca)}, "R3 cfg_rdata");
        check({8'h0, bm_rdata}, {8'h0, exp_bm(ba)}, "R6 bm_rdata");
        check({15'h0, dma_wr}, {15'h0, bw}, "R5 dma_wr");
        if (bw) check({8'h0, dma_wdata}, {8'h0, exp_dma(ba, bd)}, "R5 dma_wdata");
        mk = m_vend[1:0];
        check({14'h0, fwd_valid}, {14'h0, ev & ~mk}, "R8 fwd_valid");
        check(fwd_status, st, "R8 fwd_status");
        irq_n = |(m_flag & ~mk);
        hit = bw && (ba == 4'd1);
        for (int c = 0; c < 2; c++) begin
            logic s, k;
            s = ev[c] && st[c*8+2];
            k = (cr && ca == (c == 0 ? 8'h50 : 8'h57)) || (hit && bd[2+c]);
            if (s) m_flag[c] = 1'b1;
            else if (k) m_flag[c] = 1'b0;
        end
        if (hit) m_vend = bd[7:4];
        @(posedge clk);
        m_irq = irq_n;
        #1;
        check({15'h0, irq_out}, {15'h0, m_irq}, "R9 irq_out");
    endtask

    task automatic peek(input string tag);
        @(negedge clk);
        evt_valid = '0; cfg_rd = 1'b0; bm_wr = 1'b0; bm_addr = 4'd1; cfg_addr = 8'h50;
        #1;
        check({8'h0, bm_rdata}, {8'h0, m_vend, m_flag, 2'b00}, tag);
        check({8'h0, cfg_rdata}, {13'h0, m_flag[0], 2'b00}, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        #1;
        // R10 forward during reset
        check({14'h0, fwd_valid}, 16'h3, "R10 fwd_valid in reset");
        check(fwd_status, 16'h0, "R10 fwd_status in reset");
        check({15'h0, irq_out}, 16'h0, "R10 irq in reset");
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        peek("R10 reset state");

        // R1 set ch0, R2 no-bit2 keeps it, then read clears (R3)
        cyc(2'b01, 16'h0004, 0, 8'h00, 0, 4'd0, 8'h00);
        peek("R1 ch0 set");
        cyc(2'b11, 16'h00FB, 0, 8'h00, 0, 4'd0, 8'h00);
        peek("R2 no-bit2 event");
        cyc(2'b00, 16'h0000, 1, 8'h50, 0, 4'd0, 8'h00);
        peek("R3 cfg read clears ch0");
        // R1 ch1 then R3 read 0x57, R3 other address clears nothing
        cyc(2'b10, 16'h0400, 0, 8'h00, 0, 4'd0, 8'h00);
        cyc(2'b00, 16'h0000, 1, 8'h51, 0, 4'd0, 8'h00);
        peek("R3 other address keeps ch1");
        cyc(2'b00, 16'h0000, 1, 8'h57, 0, 4'd0, 8'h00);
        peek("R3 cfg read clears ch1");
        // R4 write-one clear and vendor store; non-vendor offset ignored
        cyc(2'b11, 16'h0404, 0, 8'h00, 0, 4'd0, 8'h00);
        cyc(2'b00, 16'h0000, 0, 8'h00, 1, 4'd9, 8'hFF);
        peek("R4 other offset ignored");
        cyc(2'b00, 16'h0000, 0, 8'h00, 1, 4'd1, 8'hA7);
        peek("R4 ch0 cleared, vendor stored");
        // R7 set wins over clear
        cyc(2'b10, 16'h0400, 0, 8'h00, 1, 4'd1, 8'h08);
        peek("R7 set wins bm clear");
        cyc(2'b01, 16'h0004, 1, 8'h50, 0, 4'd0, 8'h00);
        peek("R7 set wins cfg clear");
        // R8 masking with vendor bits 4 and 5
        cyc(2'b00, 16'h0000, 0, 8'h00, 1, 4'd1, 8'h30);
        cyc(2'b11, 16'h0404, 0, 8'h00, 0, 4'd0, 8'h00);
        cyc(2'b00, 16'h0000, 0, 8'h00, 0, 4'd0, 8'h00);
        check({15'h0, irq_out}, 16'h0, "R8 masked flags give no irq");
        cyc(2'b00, 16'h0000, 0, 8'h00, 1, 4'd1, 8'h10);
        cyc(2'b00, 16'h0000, 0, 8'h00, 0, 4'd0, 8'h00);
        check({15'h0, irq_out}, 16'h1, "R9 unmasked ch1 irq");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] ca;
            logic [3:0] ba;
            logic [15:0] st;
            case ($urandom % 4)
                0: ca = 8'h50;
                1: ca = 8'h57;
                default: ca = 8'($urandom);
            endcase
            ba = ($urandom % 2) ? 4'd1 : 4'($urandom);
            st = 16'($urandom);
            cyc(2'($urandom), st, ($urandom % 4) == 0, ca,
                ($urandom % 4) == 0, ba, 8'($urandom));
            if (i == 1500) begin
                @(negedge clk); rst_n = 1'b0; #1;
                check({14'h0, fwd_valid}, 16'h3, "R10 mid reset fwd_valid");
                check(fwd_status, 16'h0, "R10 mid reset fwd_status");
                check({15'h0, irq_out}, 16'h0, "R10 mid reset irq");
                m_flag = '0; m_vend = '0; m_irq = 1'b0;
                @(negedge clk); rst_n = 1'b1;
                peek("R10 state after mid reset");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule